// File: doc/BRIEF.md
# Write-Only I2C Synthesizer Register Receiver

This block is the serial front end of a PLL tuning synthesizer. It listens on an I2C bus as a write-only slave. When a write transfer carries its device address, it fills three configuration registers: a 15-bit divide ratio, a 7-bit control word and a 4-bit band-switch word. SCL and SDA arrive already synchronised to the system clock. The acknowledge is driven through an open-drain enable, so the block only ever pulls SDA low. Two select inputs supply the two variable bits of the device address. A second, general address is also accepted whatever those inputs hold.

After a matching address, data bytes keep arriving with auto-increment until a STOP. The top bit of the first data byte picks the register pair that comes first:
- A 0 starts the divider pair: high byte, then low byte.
- A 1 starts the control/band pair: control byte, then band byte.

Once the first pair is done, the receiver moves to the other pair. After both pairs it classifies the next byte afresh by its top bit. A register only changes when the byte that completes it has been fully clocked in. A short transfer can therefore program part of the bank and leave the rest alone.

The bus-side state machine `i2c_wr_fsm` has six states:

| State | Role | Leaves on |
|---|---|---|
| `BUS_IDLE` | waits for a START | START goes to `BUS_ADDR` |
| `BUS_ADDR` | shifts in the address byte | 8th SCL fall goes to `BUS_ADDR_ACK` on a hit, `BUS_IGNORE` on a miss |
| `BUS_ADDR_ACK` | holds SDA low for the 9th clock | SCL fall goes to `BUS_DATA` |
| `BUS_DATA` | shifts in a data byte | 8th SCL fall goes to `BUS_DATA_ACK`, with a byte strobe |
| `BUS_DATA_ACK` | holds SDA low for the 9th clock | SCL fall goes to `BUS_DATA` |
| `BUS_IGNORE` | stays off the bus | only START or STOP |

From any state, STOP goes to `BUS_IDLE` and START goes to `BUS_ADDR`.

The byte sequencer `synth_reg_decoder` has five states:

| State | Meaning of the next byte | After the byte |
|---|---|---|
| `SEQ_FIRST` | classified by bit 7 | 0 goes to `SEQ_DIV_LO`; 1 goes to `SEQ_BAND` |
| `SEQ_DIV_HI` | divider high byte | goes to `SEQ_DIV_LO` |
| `SEQ_DIV_LO` | divider low byte | goes to `SEQ_CTRL` if the divider pair came first, else `SEQ_FIRST` |
| `SEQ_CTRL` | control byte | goes to `SEQ_BAND` |
| `SEQ_BAND` | band byte | goes to `SEQ_FIRST` if the divider pair came first, else `SEQ_DIV_HI` |

START or STOP returns the sequencer to `SEQ_FIRST`.

Top module: `synth_i2c_rx`

## Requirements
- R1: An address byte of binary 11000, then the two module bits equal to `ma_sel_i[1:0]`, then R/W = 0, is acknowledged: SDA is pulled low (`sda_oe_o` = 1) for the 9th clock only, starting while SCL is low.
- R2: The address byte 0xC2 (module bits 01, write) is acknowledged whatever `ma_sel_i` holds.
- R3: An address byte with another prefix, other module bits, or R/W = 1 is not acknowledged, and every following byte is neither acknowledged nor stored until the next START.
- R4: If the first data byte has bit 7 = 0, its bits 6..0 and the next byte form the divider: `div_o` = {byte1[6:0], byte2[7:0]}.
- R5: `div_o` changes only when the low divider byte completes: one clock after the 8th SCL falling edge of that byte, the cycle the acknowledge starts. A high byte alone leaves `div_o` unchanged.
- R6: A data byte with bit 7 = 1 in first position, or any byte in the control slot, loads `ctrl_o` = byte[6:0] = {CP, T2, T1, T0, RSA, RSB, OS} after its 8th clock.
- R7: The byte after the control byte loads `bs_o` = byte[3:0] = {BS4..BS1}; byte bits 7..4 are ignored.
- R8: After the pair selected first, the other pair follows without re-addressing. After both pairs, the next byte is classified again by its bit 7.
- R9: A START or STOP resets the byte sequence, so an incomplete divider pair is discarded. STOP releases SDA on the next clock.
- R10: Reset gives `div_o` = 0, `ctrl_o` = 0x49 (CP=1, T=001, RSA=RSB=0, OS=1), `bs_o` = 0 and SDA released.
- R11: Every data byte of an addressed write is acknowledged, and the acknowledge never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| scl_i | input | 1 | bus clock, synchronised |
| sda_i | input | 1 | bus data line as seen on the wire, synchronised |
| ma_sel_i | input | 2 | module-address bits this device answers to |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| div_o | output | 15 | programmable divider ratio |
| ctrl_o | output | 7 | {CP, T2, T1, T0, RSA, RSB, OS} |
| bs_o | output | 4 | band-switch buffer enables {BS4..BS1} |

## Verification
The bus conditions come from one register stage on SCL/SDA. Every register therefore updates on the clock after the 8th SCL fall of its completing byte, and the acknowledge enable rises in that same clock. The bench holds every bus phase for three clocks and samples register values three clocks after that SCL fall, so the new value is settled and the next SCL edge has not yet arrived. The acknowledge is read in the middle of the 9th SCL-high phase, and STOP release is expected one clock after the STOP edge. One directed test samples `div_o` inside the acknowledge of the low divider byte to pin down the commit point.

// File: rtl/synth_rx_pkg.sv
package synth_rx_pkg;

    localparam int BYTE_W = 8;

    localparam logic [4:0] DEV_PREFIX = 5'b11000;
    localparam logic [1:0] GEN_MA     = 2'b01;

    typedef enum logic [2:0] {
        BUS_IDLE,
        BUS_ADDR,
        BUS_ADDR_ACK,
        BUS_DATA,
        BUS_DATA_ACK,
        BUS_IGNORE
    } bus_state_t;

    typedef enum logic [2:0] {
        SEQ_FIRST,
        SEQ_DIV_HI,
        SEQ_DIV_LO,
        SEQ_CTRL,
        SEQ_BAND
    } seq_state_t;

endpackage

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_q;
    logic sda_q;

    // Previous bus levels; idle bus is high on both lines.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SDA moving while SCL is held high marks a bus condition.
    always_comb begin
        start_o    = scl_i && scl_q && sda_q && !sda_i;
        stop_o     = scl_i && scl_q && !sda_q && sda_i;
        scl_rise_o = scl_i && !scl_q;
        scl_fall_o = !scl_i && scl_q;
    end

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import synth_rx_pkg::*;
#(
    parameter int MA_W   = 2,
    parameter bit GEN_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    input  logic [MA_W-1:0]   ma_sel_i,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    output logic              sda_oe_o
);

    localparam int PFX_W = BYTE_W - 1 - MA_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

    bus_state_t        state_q;
    bus_state_t        state_d;
    logic [BYTE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              shifting;
    logic              byte_end;
    logic              own_hit;
    logic              gen_hit;
    logic              addr_hit;

    // Address decode: fixed prefix, module bits, write direction.
    assign own_hit = (shreg_q[BYTE_W-1 -: PFX_W] == DEV_PREFIX[PFX_W-1:0])
                  && (shreg_q[MA_W:1] == ma_sel_i)
                  && !shreg_q[0];

    generate
        if (GEN_EN) begin : g_gen_addr
            assign gen_hit = (shreg_q[BYTE_W-1 -: PFX_W] == DEV_PREFIX[PFX_W-1:0])
                          && (shreg_q[MA_W:1] == GEN_MA[MA_W-1:0])
                          && !shreg_q[0];
        end else begin : g_no_gen_addr
            assign gen_hit = 1'b0;
        end
    endgenerate

    assign addr_hit = own_hit || gen_hit;
    assign shifting = (state_q == BUS_ADDR) || (state_q == BUS_DATA);
    assign byte_end = scl_fall_i && (cnt_q == CNT_FULL);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (stop_i) begin
            state_d = BUS_IDLE;
        end else if (start_i) begin
            state_d = BUS_ADDR;
        end else begin
            unique case (state_q)
                BUS_IDLE:     state_d = BUS_IDLE;
                BUS_ADDR:     if (byte_end) state_d = addr_hit ? BUS_ADDR_ACK : BUS_IGNORE;
                BUS_ADDR_ACK: if (scl_fall_i) state_d = BUS_DATA;
                BUS_DATA:     if (byte_end) state_d = BUS_DATA_ACK;
                BUS_DATA_ACK: if (scl_fall_i) state_d = BUS_DATA;
                BUS_IGNORE:   state_d = BUS_IGNORE;
                default:      state_d = BUS_IDLE;
            endcase
        end
    end

    // Bit shifter and bit counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (start_i || stop_i) begin
            cnt_q <= '0;
        end else if (shifting && scl_rise_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_i};
            cnt_q   <= cnt_q + 1'b1;
        end else if (byte_end) begin
            cnt_q <= '0;
        end
    end

    // Outputs from state.
    always_comb begin
        sda_oe_o     = 1'b0;
        byte_valid_o = 1'b0;
        unique case (state_q)
            BUS_ADDR_ACK: sda_oe_o = 1'b1;
            BUS_DATA_ACK: sda_oe_o = 1'b1;
            BUS_DATA:     byte_valid_o = byte_end && !start_i && !stop_i;
            default:      sda_oe_o = 1'b0;
        endcase
    end

    assign byte_data_o = shreg_q;

endmodule

// File: rtl/synth_reg_decoder.sv
module synth_reg_decoder
    import synth_rx_pkg::*;
#(
    parameter int              DIV_W    = 15,
    parameter int              CTRL_W   = 7,
    parameter int              BS_W     = 4,
    parameter logic [CTRL_W-1:0] CTRL_RST = 7'h49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_clr_i,
    input  logic              byte_valid_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [DIV_W-1:0]  div_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [BS_W-1:0]   bs_o
);

    localparam int HI_W = DIV_W - BYTE_W;

    seq_state_t      seq_q;
    seq_state_t      seq_d;
    logic            div_first_q;
    logic            div_first_d;
    logic [HI_W-1:0] div_hi_q;
    logic            ld_hi;
    logic            ld_div;
    logic            ld_ctrl;
    logic            ld_bs;

    // Sequencer state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= SEQ_FIRST;
            div_first_q <= 1'b0;
        end else begin
            seq_q       <= seq_d;
            div_first_q <= div_first_d;
        end
    end

    // Byte classification and pointer advance.
    always_comb begin
        seq_d       = seq_q;
        div_first_d = div_first_q;
        ld_hi       = 1'b0;
        ld_div      = 1'b0;
        ld_ctrl     = 1'b0;
        ld_bs       = 1'b0;
        if (seq_clr_i) begin
            seq_d = SEQ_FIRST;
        end else if (byte_valid_i) begin
            unique case (seq_q)
                SEQ_FIRST: begin
                    if (byte_i[BYTE_W-1]) begin
                        ld_ctrl     = 1'b1;
                        div_first_d = 1'b0;
                        seq_d       = SEQ_BAND;
                    end else begin
                        ld_hi       = 1'b1;
                        div_first_d = 1'b1;
                        seq_d       = SEQ_DIV_LO;
                    end
                end
                SEQ_DIV_HI: begin
                    ld_hi = 1'b1;
                    seq_d = SEQ_DIV_LO;
                end
                SEQ_DIV_LO: begin
                    ld_div = 1'b1;
                    seq_d  = div_first_q ? SEQ_CTRL : SEQ_FIRST;
                end
                SEQ_CTRL: begin
                    ld_ctrl = 1'b1;
                    seq_d   = SEQ_BAND;
                end
                SEQ_BAND: begin
                    ld_bs = 1'b1;
                    seq_d = div_first_q ? SEQ_FIRST : SEQ_DIV_HI;
                end
                default: seq_d = SEQ_FIRST;
            endcase
        end
    end

    // Register bank.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_hi_q <= '0;
            div_o    <= '0;
            ctrl_o   <= CTRL_RST;
            bs_o     <= '0;
        end else begin
            if (ld_hi)   div_hi_q <= byte_i[HI_W-1:0];
            if (ld_div)  div_o    <= {div_hi_q, byte_i};
            if (ld_ctrl) ctrl_o   <= byte_i[CTRL_W-1:0];
            if (ld_bs)   bs_o     <= byte_i[BS_W-1:0];
        end
    end

endmodule

// File: rtl/synth_i2c_rx.sv
module synth_i2c_rx
    import synth_rx_pkg::*;
#(
    parameter int                DIV_W    = 15,
    parameter int                CTRL_W   = 7,
    parameter int                BS_W     = 4,
    parameter int                MA_W     = 2,
    parameter bit                GEN_EN   = 1'b1,
    parameter logic [CTRL_W-1:0] CTRL_RST = 7'h49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [MA_W-1:0]   ma_sel_i,
    output logic              sda_oe_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [BS_W-1:0]   bs_o
);

    logic              start_w;
    logic              stop_w;
    logic              rise_w;
    logic              fall_w;
    logic              bvalid_w;
    logic [BYTE_W-1:0] bdata_w;

    i2c_cond_detect u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .start_o    (start_w),
        .stop_o     (stop_w),
        .scl_rise_o (rise_w),
        .scl_fall_o (fall_w)
    );

    i2c_wr_fsm #(
        .MA_W   (MA_W),
        .GEN_EN (GEN_EN)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_w),
        .stop_i       (stop_w),
        .scl_rise_i   (rise_w),
        .scl_fall_i   (fall_w),
        .sda_i        (sda_i),
        .ma_sel_i     (ma_sel_i),
        .byte_valid_o (bvalid_w),
        .byte_data_o  (bdata_w),
        .sda_oe_o     (sda_oe_o)
    );

    synth_reg_decoder #(
        .DIV_W    (DIV_W),
        .CTRL_W   (CTRL_W),
        .BS_W     (BS_W),
        .CTRL_RST (CTRL_RST)
    ) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .seq_clr_i    (start_w || stop_w),
        .byte_valid_i (bvalid_w),
        .byte_i       (bdata_w),
        .div_o        (div_o),
        .ctrl_o       (ctrl_o),
        .bs_o         (bs_o)
    );

endmodule

// File: rtl/synth_i2c_rx_chk.sv
module synth_i2c_rx_chk #(
    parameter int                DIV_W    = 15,
    parameter int                CTRL_W   = 7,
    parameter int                BS_W     = 4,
    parameter logic [CTRL_W-1:0] CTRL_RST = 7'h49
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_oe_o,
    input logic [DIV_W-1:0]  div_o,
    input logic [CTRL_W-1:0] ctrl_o,
    input logic [BS_W-1:0]   bs_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assert_reset_vals_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (div_o == '0) && (ctrl_o == CTRL_RST) && (bs_o == '0) && !sda_oe_o);

    assert_div_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_o) |-> $rose(sda_oe_o));

    assert_ctrl_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_o) |-> $rose(sda_oe_o));

    assert_bs_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bs_o) |-> $rose(sda_oe_o));

    assert_ack_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    assert_ack_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && scl_q && !sda_q && sda_i) |=> !sda_oe_o);

endmodule

bind synth_i2c_rx synth_i2c_rx_chk #(
    .DIV_W    (DIV_W),
    .CTRL_W   (CTRL_W),
    .BS_W     (BS_W),
    .CTRL_RST (CTRL_RST)
) u_chk (.*);

// File: tb/synth_i2c_rx_test.sv
module synth_i2c_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 3;
    localparam int NV         = 7;

    typedef struct packed {
        logic [2:0]  n;
        logic [39:0] bytes;
        logic        ack;
        logic [14:0] div;
        logic [6:0]  ctrl;
        logic [3:0]  bs;
    } vec_t;

    // ma_sel = 10, so the own address is 0xC4.
    localparam vec_t VECS [NV] = '{
        {3'd5, 40'hC4_12_34_C6_0A, 1'b1, 15'h1234, 7'h46, 4'hA}, // R1 R4 R6 R7 R8
        {3'd5, 40'hC2_85_F3_7F_FF, 1'b1, 15'h7FFF, 7'h05, 4'h3}, // R2 R8
        {3'd2, 40'hC4_05_00_00_00, 1'b1, 15'h7FFF, 7'h05, 4'h3}, // R5 high byte only
        {3'd3, 40'hC6_00_00_00_00, 1'b0, 15'h7FFF, 7'h05, 4'h3}, // R3 wrong module bits
        {3'd1, 40'hC5_00_00_00_00, 1'b0, 15'h7FFF, 7'h05, 4'h3}, // R3 read request
        {3'd2, 40'hC4_C9_00_00_00, 1'b1, 15'h7FFF, 7'h49, 4'h3}, // R6 control only
        {3'd3, 40'hC4_01_00_00_00, 1'b1, 15'h0100, 7'h49, 4'h3}  // R4 divider only
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  ma_sel = 2'b10;
    logic        sda_oe;
    logic        sda_line;
    logic [14:0] div;
    logic [6:0]  ctrl;
    logic [3:0]  bs;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    vec_t        t;
    logic        a;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_i2c_rx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .ma_sel_i (ma_sel),
        .sda_oe_o (sda_oe),
        .div_o    (div),
        .ctrl_o   (ctrl),
        .bs_o     (bs)
    );

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic bits8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(); wq();
            scl_m = 1'b0; wq();
        end
    endtask

    task automatic ack_bit(output logic acked);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        acked = !sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        bits8(b);
        ack_bit(acked);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10 div reset", 32'(div), 32'h0);
        chk("R10 ctrl reset", 32'(ctrl), 32'h49);
        chk("R10 bs reset", 32'(bs), 32'h0);
        chk("R10 sda released", 32'(sda_oe), 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Table of transfers
        for (int v = 0; v < NV; v++) begin
            t = VECS[v];
            bus_start();
            for (int k = 0; k < 32'(t.n); k++) begin
                wr_byte(t.bytes[39-8*k -: 8], a);
                chk("R1 R2 R3 R11 ack", 32'(a), 32'(t.ack));
            end
            bus_stop();
            wq();
            chk("R4 R5 div", 32'(div), 32'(t.div));
            chk("R6 ctrl", 32'(ctrl), 32'(t.ctrl));
            chk("R7 bs", 32'(bs), 32'(t.bs));
        end

        // R5 R9: commit point, repeated START discards a lone high byte
        bus_start();
        wr_byte(8'hC4, a);
        wr_byte(8'h22, a);
        chk("R5 no commit on high byte", 32'(div), 32'h0100);
        bus_start();
        wr_byte(8'hC4, a);
        wr_byte(8'h33, a);
        chk("R5 R9 high byte held", 32'(div), 32'h0100);
        bits8(8'h44);
        chk("R5 commit at low byte end", 32'(div), 32'h3344);
        chk("R11 ack driven at commit", 32'(sda_oe), 32'h1);
        ack_bit(a);
        chk("R11 low byte ack", 32'(a), 32'h1);
        bus_stop();
        wq();
        chk("R9 stop releases sda", 32'(sda_oe), 32'h0);

        // R9: STOP resets sequence; next first byte is classified anew
        bus_start();
        wr_byte(8'hC4, a);
        wr_byte(8'h55, a);
        bus_stop();
        bus_start();
        wr_byte(8'hC4, a);
        wr_byte(8'h8D, a);
        bus_stop();
        wq();
        chk("R9 div kept after stop", 32'(div), 32'h3344);
        chk("R9 ctrl after reclassify", 32'(ctrl), 32'h0D);

        // R8: control pair first, then divider, then classification again
        bus_start();
        wr_byte(8'hC4, a);
        wr_byte(8'h81, a);
        wr_byte(8'h07, a);
        wr_byte(8'h00, a);
        wr_byte(8'h02, a);
        wr_byte(8'h90, a);
        wr_byte(8'hFC, a);
        bus_stop();
        wq();
        chk("R8 div second pair", 32'(div), 32'h0002);
        chk("R8 ctrl reclassified", 32'(ctrl), 32'h10);
        chk("R7 R8 bs upper ignored", 32'(bs), 32'hC);

        // R3: ignored bytes until repeated START, then normal operation
        bus_start();
        wr_byte(8'hCC, a);
        chk("R3 prefix mismatch nack", 32'(a), 32'h0);
        wr_byte(8'h05, a);
        chk("R3 ignored byte nack", 32'(a), 32'h0);
        wr_byte(8'h06, a);
        bus_start();
        wr_byte(8'hC4, a);
        chk("R1 ack after restart", 32'(a), 32'h1);
        wr_byte(8'h03, a);
        wr_byte(8'h04, a);
        bus_stop();
        wq();
        chk("R3 R4 div after restart", 32'(div), 32'h0304);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule